// File: doc/BRIEF.md
# Per-Thread Set-Dueling Insertion Policy Selector

This block decides, for every hardware thread that shares a cache, whether the lines that thread brings in are placed at the most-recently-used end of the replacement order (LRU insertion) or mostly at the least-recently-used end (bimodal insertion, BIP). The decision is learned at run time. A fixed pattern of set indices sets aside a small group of sample sets per thread in which that thread always inserts with LRU, and a second group in which it always inserts with BIP. Each thread also has a saturating selector counter. Misses in the first group push the counter up and misses in the second group pull it down. The top bit of the counter is the thread's learned policy.

A sample set belongs to exactly one thread. For every other thread it is an ordinary set, so each thread's choice is measured while all other threads run their own learned policies. The cache controller presents each miss as a strobe with the set index and the requesting thread. It takes back the insertion policy to use for that fill in the same cycle. The per-thread policy bits are also available at all times. The counter width defaults to 10 bits, or 9 bits when only two threads share the cache, so the state is the counter width times the thread count.

Top module: `tps_policy_sel`

## Requirements
- R1: After reset every selector counter holds its midpoint (top bit 1, all other bits 0), so every bit of `thread_bip` reads 1.
- R2: With STRIDE = NUM_SETS / SETS_PER_GROUP (32 by default), let k = set index mod STRIDE. A set is LRU-sampled for thread k when k < NUM_THREADS. It is BIP-sampled for thread k - NUM_THREADS when NUM_THREADS <= k < 2*NUM_THREADS. Every other set is a follower set.
- R3: A miss in a set LRU-sampled for thread t increments thread t's counter on the next clock edge, whichever thread caused the miss.
- R4: A miss in a set BIP-sampled for thread t decrements thread t's counter on the next clock edge, whichever thread caused the miss.
- R5: Counters saturate: an increment at all-ones and a decrement at zero leave the counter unchanged.
- R6: `thread_bip[t]` is the top bit of thread t's counter: 0 means LRU insertion and 1 means BIP insertion.
- R7: For a miss in a follower set, `fill_bip` equals `thread_bip[miss_tid]`.
- R8: For a miss by thread t in a set sampled for thread t, `fill_bip` is 0 in its LRU-sampled sets and 1 in its BIP-sampled sets, whatever its counter holds.
- R9: For a miss by thread t in a set sampled for another thread, `fill_bip` equals `thread_bip[t]`.
- R10: Cycles without a miss, and misses in follower sets, leave all counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_set | input | 10 | Set index of the miss |
| miss_tid | input | 2 | Hardware thread that missed |
| fill_bip | output | 1 | Insertion policy for this fill (0 LRU, 1 BIP), valid while miss_valid is high |
| thread_bip | output | 4 | Learned policy bit of each thread |

## Verification
The embedded properties check on every cycle the single-step up and down moves of each counter, saturation at both ends, stability when nothing is counted, and the choice of `fill_bip` among forced and learned policy in owner, other-thread and follower sets. The properties cannot show the set-to-group mapping itself, the midpoint reset value, or whether a counter crosses its top bit after exactly the right number of misses. The bench shows these with a reference model of all counters. Its longest scenario drives one counter past both saturation limits and then confirms that the policy bit flips only after exactly 512 opposing misses.

// File: rtl/tps_pkg.sv
package tps_pkg;

   typedef enum logic {
      POL_LRU = 1'b0,
      POL_BIP = 1'b1
   } pol_e;

   // Selector width: narrower when only two threads compete.
   function automatic int sel_width(input int n_threads);
      return (n_threads == 2) ? 9 : 10;
   endfunction

endpackage

// File: rtl/tps_set_map.sv
module tps_set_map #(
   parameter int NUM_SETS       = 1024,
   parameter int NUM_THREADS    = 4,
   parameter int SETS_PER_GROUP = 32,
   localparam int SET_W  = $clog2(NUM_SETS),
   localparam int TID_W  = $clog2(NUM_THREADS),
   localparam int STRIDE = NUM_SETS / SETS_PER_GROUP
) (
   input  logic [SET_W-1:0] set_idx,
   output logic             is_lru,
   output logic             is_bip,
   output logic [TID_W-1:0] owner
);

   logic [SET_W-1:0] slot;

   generate
      if (STRIDE * SETS_PER_GROUP != NUM_SETS) begin : g_bad_div
         $error("NUM_SETS must be a multiple of SETS_PER_GROUP");
      end
      if ((1 << $clog2(STRIDE)) != STRIDE) begin : g_bad_pow
         $error("set stride must be a power of two");
      end
      if (2 * NUM_THREADS > STRIDE) begin : g_bad_room
         $error("not enough slots per stride for all sample groups");
      end
   endgenerate

   always_comb begin
      slot   = set_idx & SET_W'(STRIDE - 1);
      is_lru = (slot < SET_W'(NUM_THREADS));
      is_bip = !is_lru && (slot < SET_W'(2 * NUM_THREADS));
      if (is_lru)
         owner = TID_W'(slot);
      else
         owner = TID_W'(slot - SET_W'(NUM_THREADS));
   end

endmodule

// File: rtl/tps_sel_ctr.sv
module tps_sel_ctr #(
   parameter int WIDTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             down,
   output logic [WIDTH-1:0] value
);

   localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] MIDV = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2) begin : g_bad_w
         $error("selector counter needs at least two bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= MIDV;
      else if (up && value != MAXV)
         value <= value + 1'b1;
      else if (down && value != '0)
         value <= value - 1'b1;
   end

   AST_CTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !down && value != MAXV) |=> value == $past(value) + 1'b1); // R3
   AST_CTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (down && !up && value != '0) |=> value == $past(value) - 1'b1); // R4
   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (up && value == MAXV) |=> value == MAXV); // R5
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (down && value == '0) |=> value == '0); // R5
   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!up && !down) |=> $stable(value)); // R10
   AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && down)); // R2

endmodule

// File: rtl/tps_policy_sel.sv
module tps_policy_sel #(
   parameter int NUM_SETS       = 1024,
   parameter int NUM_THREADS    = 4,
   parameter int SETS_PER_GROUP = 32,
   parameter int SEL_W          = tps_pkg::sel_width(NUM_THREADS),
   localparam int SET_W = $clog2(NUM_SETS),
   localparam int TID_W = $clog2(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   miss_valid,
   input  logic [SET_W-1:0]       miss_set,
   input  logic [TID_W-1:0]       miss_tid,
   output logic                   fill_bip,
   output logic [NUM_THREADS-1:0] thread_bip
);

   import tps_pkg::*;

   logic             smp_lru;
   logic             smp_bip;
   logic [TID_W-1:0] smp_owner;
   logic             own_sample;
   pol_e             fill_pol;

   generate
      if (NUM_THREADS < 2) begin : g_bad_nt
         $error("at least two threads are required");
      end
   endgenerate

   tps_set_map #(
      .NUM_SETS       (NUM_SETS),
      .NUM_THREADS    (NUM_THREADS),
      .SETS_PER_GROUP (SETS_PER_GROUP)
   ) u_map (
      .set_idx (miss_set),
      .is_lru  (smp_lru),
      .is_bip  (smp_bip),
      .owner   (smp_owner)
   );

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic             bump_up;
      logic             bump_down;
      logic [SEL_W-1:0] sel_q;

      assign bump_up   = miss_valid && smp_lru && (smp_owner == TID_W'(t));
      assign bump_down = miss_valid && smp_bip && (smp_owner == TID_W'(t));

      tps_sel_ctr #(.WIDTH(SEL_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .up    (bump_up),
         .down  (bump_down),
         .value (sel_q)
      );

      assign thread_bip[t] = sel_q[SEL_W-1];
   end

   always_comb begin
      own_sample = (smp_lru || smp_bip) && (smp_owner == miss_tid);
      if (own_sample)
         fill_pol = smp_bip ? POL_BIP : POL_LRU;
      else
         fill_pol = thread_bip[miss_tid] ? POL_BIP : POL_LRU;
      fill_bip = (fill_pol == POL_BIP);
   end

   AST_FOLLOWER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && !smp_lru && !smp_bip) |-> fill_bip == thread_bip[miss_tid]); // R7
   AST_OWNER_LRU: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && smp_lru && smp_owner == miss_tid) |-> !fill_bip); // R8
   AST_OWNER_BIP: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && smp_bip && smp_owner == miss_tid) |-> fill_bip); // R8
   AST_FOREIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && (smp_lru || smp_bip) && smp_owner != miss_tid)
         |-> fill_bip == thread_bip[miss_tid]); // R9
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_valid |=> $stable(thread_bip)); // R10
   AST_FOLLOWER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && !smp_lru && !smp_bip) |=> $stable(thread_bip)); // R10

endmodule

// File: tb/tps_policy_sel_test.sv
module tps_policy_sel_test;

   localparam int PERIOD = 10;
   localparam int NT     = 4;
   localparam int NSETS  = 1024;
   localparam int STRIDE = 32;
   localparam int MAXV   = 1023;
   localparam int MIDV   = 512;

   typedef struct {
      bit             has_fill;
      bit             fill_exp;
      logic [NT-1:0]  bits_exp;
      string          tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [9:0]    miss_set = '0;
   logic [1:0]    miss_tid = '0;
   logic          fill_bip;
   logic [NT-1:0] thread_bip;

   int    model [NT];
   item_t sb_q [$];
   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   tps_policy_sel uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .miss_set   (miss_set),
      .miss_tid   (miss_tid),
      .fill_bip   (fill_bip),
      .thread_bip (thread_bip)
   );

   always #(PERIOD/2) clk = ~clk;

   function automatic logic [NT-1:0] model_bits();
      logic [NT-1:0] b;
      for (int t = 0; t < NT; t++) b[t] = (model[t] >= MIDV);
      return b;
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s fill_bip actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic check_vec(input string tag, input logic [NT-1:0] act,
                            input logic [NT-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s thread_bip actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Driver: one miss per cycle, expectation from the requirement model.
   task automatic do_miss(input int set, input int tid, input string tag);
      item_t it;
      int    slot;
      int    own;
      bit    lru;
      bit    bip;
      @(negedge clk);
      miss_valid = 1'b1;
      miss_set   = 10'(set);
      miss_tid   = 2'(tid);
      slot = set % STRIDE;
      lru  = (slot < NT);
      bip  = (slot >= NT) && (slot < 2*NT);
      own  = lru ? slot : slot - NT;
      it.has_fill = 1'b1;
      it.bits_exp = model_bits();
      if ((lru || bip) && own == tid) it.fill_exp = bip;
      else                            it.fill_exp = (model[tid] >= MIDV);
      it.tag = tag;
      sb_q.push_back(it);
      if (lru && model[own] < MAXV) model[own]++;
      if (bip && model[own] > 0)    model[own]--;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         item_t it;
         @(negedge clk);
         miss_valid = 1'b0;
         it.has_fill = 1'b0;
         it.fill_exp = 1'b0;
         it.bits_exp = model_bits();
         it.tag = tag;
         sb_q.push_back(it);
      end
   endtask

   // Monitor: samples a quarter period after each falling edge.
   initial begin
      forever begin
         @(negedge clk);
         #(PERIOD/4);
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check_vec(it.tag, thread_bip, it.bits_exp);
            if (it.has_fill) check_bit(it.tag, fill_bip, it.fill_exp);
         end
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < NT; t++) model[t] = MIDV;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #(PERIOD/4);
      check_vec("R1", thread_bip, '1);   // R1: midpoint reset

      idle(2, "R10");
      // R7: follower sets, all threads BIP after reset; R10: no counter move
      do_miss(40, 0, "R7");
      do_miss(63, 1, "R7");
      do_miss(1000, 2, "R2");            // slot 8 is a follower
      do_miss(200, 3, "R10");
      // R8: owner forced to LRU in its LRU-sampled set, counter 0 rises (R3)
      do_miss(0, 0, "R8");
      do_miss(32*7 + 0, 0, "R3");
      // R8: owner forced to BIP, counter 1 falls (R4), MSB drops (R6)
      do_miss(32*3 + NT + 1, 1, "R8");
      do_miss(NT + 1, 1, "R4");
      do_miss(32*9 + NT + 1, 1, "R6");
      do_miss(41, 1, "R7");              // follower now LRU for thread 1
      // R9: another thread in thread 1's LRU set uses own policy; R3 for owner
      do_miss(993, 2, "R9");
      do_miss(993, 2, "R3");
      do_miss(32*4 + NT + 0, 2, "R9");   // thread 0 BIP set, thread 2 misses
      do_miss(32*4 + NT + 0, 3, "R4");
      idle(2, "R6");

      // R5: drive thread 3 past both limits
      for (int i = 0; i < 600; i++) do_miss(32*5 + 3, 1, "R5");
      for (int i = 0; i < 512; i++) do_miss(32*5 + NT + 3, 3, "R5");
      for (int i = 0; i < 600; i++) do_miss(32*6 + NT + 3, 0, "R5");
      for (int i = 0; i < 512; i++) do_miss(32*2 + 3, 3, "R5");
      idle(3, "R5");

      wait (sb_q.size() == 0);
      @(negedge clk);
      #(PERIOD/2);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule